// File: doc/BRIEF.md
# Low-Power March Memory Self-Test Controller

This block drives a synchronous single-port RAM through a march test built to keep switching activity low. After a start request it visits every address once, in ascending order with the column field changing fastest. At each address it issues four one-cycle operations back to back: write a pattern, read it, write the inverse, read the inverse. Two patterns are available: all zeros (the zero-one test) and a checkerboard, where odd addresses get all ones and even addresses get all zeros. Doing all four operations at one address before moving on keeps the address lines quiet.

Each read is compared against the expected word one cycle after it is issued, when the RAM returns its data. The first mismatch latches a fail flag and the failing address. The run still goes on to the end. A one-cycle done pulse closes the run.

The block also drives a per-column precharge enable for each RAM column. The address order is fixed, so the next column is always known in advance. In low-power mode only the selected column and the one after it are precharged. With low-power mode off, every column is precharged while the test is running.

Top module: `mbist_lp_ctrl`

## Requirements
- R1: After reset, done, fail, mem_we and mem_re are 0, every bit of col_prech is 0 and fail_addr is 0.
- R2: A run visits the linear addresses 0 to 2^(ROW_BITS+COL_BITS)-1 in ascending order. The address is {row, column}, so the column field changes fastest. Each address receives exactly four consecutive one-cycle operations before the next address is driven. The first operation is issued in the cycle after the clock edge that accepts start.
- R3: With algo_sel=0 (zero-one), the four operations at each address are: write all zeros, read, write all ones, read. A write cycle has mem_we=1 and mem_re=0. A read cycle has mem_re=1 and mem_we=0.
- R4: With algo_sel=1 (checkerboard), the first write at an address stores all ones if address bit 0 is 1 and all zeros if it is 0. The second write stores the bitwise inverse of the first. Each read expects the value written just before it.
- R5: Read data is sampled one cycle after the read is issued and compared with the expected word. The first mismatch of a run sets fail and captures that read's address in fail_addr. Later mismatches in the same run leave fail_addr unchanged, and the run continues to completion.
- R6: done is high for exactly one cycle. That cycle comes 4*2^(ROW_BITS+COL_BITS)+2 cycles after the clock edge that accepts start. No memory operation is issued in the cycle between the last operation and done.
- R7: start is accepted only while the controller is idle. A start request during a run does not change the address or operation sequence.
- R8: With lp_mode=1 during a run, col_prech has bit c set for the selected column c and for column c+1 only. When the last column is selected, only its own bit is set.
- R9: With lp_mode=0 during a run, all col_prech bits are 1. Outside a run, all col_prech bits are 0.
- R10: An accepted start clears fail and fail_addr, so a fault-free run reports fail=0 even after a failing run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Run request, taken only when idle |
| algo_sel | input | 1 | 0 selects zero-one, 1 selects checkerboard; latched at start |
| lp_mode | input | 1 | 1 selects restricted precharge |
| mem_addr | output | ROW_BITS+COL_BITS | RAM address {row, column} |
| mem_wdata | output | DATA_W | RAM write data |
| mem_we | output | 1 | RAM write enable |
| mem_re | output | 1 | RAM read enable |
| mem_rdata | input | DATA_W | RAM read data, valid the cycle after a read |
| col_prech | output | 2^COL_BITS | Per-column precharge enable |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | A mismatch was seen since the last start |
| fail_addr | output | ROW_BITS+COL_BITS | Address of the first mismatch |

## Verification
A behavioural RAM is run first with no fault, once per algorithm and with each precharge mode. This shows that operation order, data and precharge pattern are correct on every cycle, and that a clean array never reports a failure. A stuck-at-0 bit at one address under the zero-one test shows that the failure is seen only on the read of ones. Two stuck cells of opposite polarity under the checkerboard show that the even/odd pattern catches both and that only the first address is kept. A start request injected mid-run and a clean run after a failing one separate the ignore-while-busy behaviour from the clear-on-start behaviour.

// File: rtl/mbist_lp_pkg.sv
// Shared types of the low-power march controller.
// Assumes nothing beyond a single clock domain.
package mbist_lp_pkg;

    // Controller phases: idle, issuing operations, waiting for the last compare.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } run_state_t;

    // The four operations applied to each address, in issue order.
    typedef enum logic [1:0] {
        OP_WR_PAT = 2'd0,
        OP_RD_PAT = 2'd1,
        OP_WR_INV = 2'd2,
        OP_RD_INV = 2'd3
    } march_op_t;

endpackage

// File: rtl/mbist_lp_seq.sv
// Address and operation sequencer.
// Walks row by row, with the column as the fast field, and applies four
// operations per address. Assumes advance is held for the whole run.
module mbist_lp_seq
    import mbist_lp_pkg::*;
#(
    parameter int ROW_BITS = 2,
    parameter int COL_BITS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                advance,
    output logic [ROW_BITS-1:0] row,
    output logic [COL_BITS-1:0] col,
    output march_op_t           op,
    output logic                last_op
);
    localparam logic [ROW_BITS-1:0] ROW_LAST = {ROW_BITS{1'b1}};
    localparam logic [COL_BITS-1:0] COL_LAST = {COL_BITS{1'b1}};

    logic [ROW_BITS-1:0] row_q;
    logic [COL_BITS-1:0] col_q;
    march_op_t           op_q;
    logic                addr_done;

    assign addr_done = (op_q == OP_RD_INV);
    assign last_op   = addr_done && (row_q == ROW_LAST) && (col_q == COL_LAST);
    assign row       = row_q;
    assign col       = col_q;
    assign op        = op_q;

    // Step operation, then column, then row.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            row_q <= '0;
            col_q <= '0;
            op_q  <= OP_WR_PAT;
        end else if (advance) begin
            op_q <= march_op_t'(op_q + 2'd1);
            if (addr_done) begin
                col_q <= col_q + 1'b1;
                if (col_q == COL_LAST) begin
                    row_q <= row_q + 1'b1;
                end
            end
        end
    end

    // R2: the address moves up by one only after the fourth operation.
    p_addr_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !clear && addr_done && !last_op)
            |=> ({row_q, col_q} == $past({row_q, col_q}) + 1'b1));

    p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !clear && !addr_done) |=> $stable({row_q, col_q}));

endmodule

// File: rtl/mbist_lp_precharge.sv
// Per-column precharge enable decoder.
// In restricted mode, only the selected column and its right neighbour are
// enabled. Assumes col is stable for the whole operation cycle.
module mbist_lp_precharge #(
    parameter int COL_BITS = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   active,
    input  logic                   lp_mode,
    input  logic [COL_BITS-1:0]    col,
    output logic [2**COL_BITS-1:0] prech
);
    localparam int NCOL = 2 ** COL_BITS;

    for (genvar c = 0; c < NCOL; c++) begin : g_col
        if (c == 0) begin : g_first
            // Column 0 is enabled only when it is selected itself.
            assign prech[c] = active && (!lp_mode || (col == COL_BITS'(c)));
        end else begin : g_rest
            // Enabled when selected, or when its left neighbour is selected.
            assign prech[c] = active && (!lp_mode || (col == COL_BITS'(c)) ||
                                         (col == COL_BITS'(c - 1)));
        end
    end

    // R8: restricted mode enables one pair, or a single column at the last one.
    p_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && lp_mode) |->
            (prech[col] && ($countones(prech) ==
                            ((col == COL_BITS'(NCOL - 1)) ? 1 : 2))));

    // R9: full precharge when restricted mode is off; none when not running.
    p_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !lp_mode) |-> (&prech));

    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (prech == '0));

endmodule

// File: rtl/mbist_lp_resp.sv
// Read response checker.
// Registers each issued read and compares RAM data with the expected word one
// cycle later. Keeps only the first failing address. Assumes RAM read latency
// is exactly one cycle.
module mbist_lp_resp #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              rd_issue,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_exp,
    input  logic [DATA_W-1:0] rdata,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic              cmp_pend
);
    logic              pend_q;
    logic [ADDR_W-1:0] pend_addr_q;
    logic [DATA_W-1:0] pend_exp_q;
    logic              fail_q;
    logic [ADDR_W-1:0] fail_addr_q;
    logic              mismatch;

    assign mismatch  = pend_q && (rdata != pend_exp_q);
    assign fail      = fail_q;
    assign fail_addr = fail_addr_q;
    assign cmp_pend  = pend_q;

    // Hold the address and expected data of the read in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            pend_addr_q <= '0;
            pend_exp_q  <= '0;
        end else begin
            pend_q      <= rd_issue;
            pend_addr_q <= rd_addr;
            pend_exp_q  <= rd_exp;
        end
    end

    // Latch the first mismatch; an accepted start wipes the result.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            fail_q      <= 1'b0;
            fail_addr_q <= '0;
        end else if (mismatch && !fail_q) begin
            fail_q      <= 1'b1;
            fail_addr_q <= pend_addr_q;
        end
    end

    // R5: once set, the failure and its address hold until the next start.
    p_fail_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_q && !clear) |=> (fail_q && $stable(fail_addr_q)));

    // R5: a compare follows each issued read by one cycle.
    p_cmp_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_issue |=> pend_q);

    // R10: clear leaves a clean result.
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!fail_q && (fail_addr_q == '0)));

endmodule

// File: rtl/mbist_lp_ctrl.sv
// Low-power march memory self-test controller (top).
// Runs the zero-one or checkerboard test with all four operations merged per
// address, checks the read data, and drives restricted column precharge.
// Assumes a single-port RAM with one-cycle synchronous reads.
module mbist_lp_ctrl
    import mbist_lp_pkg::*;
#(
    parameter int ROW_BITS = 2,
    parameter int COL_BITS = 2,
    parameter int DATA_W   = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic                         algo_sel,
    input  logic                         lp_mode,
    output logic [ROW_BITS+COL_BITS-1:0] mem_addr,
    output logic [DATA_W-1:0]            mem_wdata,
    output logic                         mem_we,
    output logic                         mem_re,
    input  logic [DATA_W-1:0]            mem_rdata,
    output logic [2**COL_BITS-1:0]       col_prech,
    output logic                         done,
    output logic                         fail,
    output logic [ROW_BITS+COL_BITS-1:0] fail_addr
);
    localparam int ADDR_W = ROW_BITS + COL_BITS;

    run_state_t          state_q;
    logic                algo_q;
    logic                done_q;
    logic                start_acc;
    logic                running;
    logic [ROW_BITS-1:0] row;
    logic [COL_BITS-1:0] col;
    march_op_t           op;
    logic                last_op;
    logic [ADDR_W-1:0]   addr;
    logic [DATA_W-1:0]   pat;
    logic [DATA_W-1:0]   word;
    logic                cmp_pend;

    assign start_acc = start && (state_q == ST_IDLE);
    assign running   = (state_q == ST_RUN);
    assign addr      = {row, col};

    // Base pattern: zeros, or a parity-selected word for the checkerboard.
    assign pat  = algo_q ? {DATA_W{addr[0]}} : '0;
    assign word = (op == OP_WR_INV || op == OP_RD_INV) ? ~pat : pat;

    assign mem_addr  = addr;
    assign mem_wdata = word;
    assign mem_we    = running && (op == OP_WR_PAT || op == OP_WR_INV);
    assign mem_re    = running && (op == OP_RD_PAT || op == OP_RD_INV);
    assign done      = done_q;

    // Phase control: idle, run the array, drain the last compare.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            algo_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= (state_q == ST_DRAIN);
            unique case (state_q)
                ST_IDLE: if (start) begin
                    state_q <= ST_RUN;
                    algo_q  <= algo_sel;
                end
                ST_RUN:   if (last_op) state_q <= ST_DRAIN;
                ST_DRAIN: state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    mbist_lp_seq #(
        .ROW_BITS(ROW_BITS),
        .COL_BITS(COL_BITS)
    ) seq_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (start_acc),
        .advance(running),
        .row    (row),
        .col    (col),
        .op     (op),
        .last_op(last_op)
    );

    mbist_lp_precharge #(
        .COL_BITS(COL_BITS)
    ) prech_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (running),
        .lp_mode(lp_mode),
        .col    (col),
        .prech  (col_prech)
    );

    mbist_lp_resp #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) resp_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (start_acc),
        .rd_issue (mem_re),
        .rd_addr  (addr),
        .rd_exp   (word),
        .rdata    (mem_rdata),
        .fail     (fail),
        .fail_addr(fail_addr),
        .cmp_pend (cmp_pend)
    );

    // R3: a cycle never both writes and reads.
    p_we_re_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R6: done lasts a single cycle.
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: the drain cycle issues nothing but still compares the last read.
    p_drain_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN) |-> (!mem_we && !mem_re && cmp_pend));

    // R7: a start request mid-run does not cut the run short.
    p_busy_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (running && start && !last_op) |=> running);

endmodule

// File: tb/mbist_lp_ctrl_tb_top.sv
// Bench for the low-power march controller.
// Uses a behavioural RAM with injectable stuck bits and checks every cycle of
// each run against values computed from the address and step.
module mbist_lp_ctrl_tb_top;
    localparam int RB    = 2;
    localparam int CB    = 2;
    localparam int DW    = 8;
    localparam int AW    = RB + CB;
    localparam int DEPTH = 2 ** AW;
    localparam int NCOL  = 2 ** CB;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic            algo_sel = 1'b0;
    logic            lp_mode = 1'b0;
    logic [AW-1:0]   mem_addr;
    logic [DW-1:0]   mem_wdata;
    logic            mem_we;
    logic            mem_re;
    logic [DW-1:0]   mem_rdata;
    logic [NCOL-1:0] col_prech;
    logic            done;
    logic            fail;
    logic [AW-1:0]   fail_addr;

    int n_run = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    mbist_lp_ctrl #(.ROW_BITS(RB), .COL_BITS(CB), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .algo_sel(algo_sel),
        .lp_mode(lp_mode), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata),
        .col_prech(col_prech), .done(done), .fail(fail), .fail_addr(fail_addr)
    );

    // Behavioural RAM with up to two stuck bits.
    logic [DW-1:0] ram [DEPTH];
    bit            sk_en [2];
    int            sk_addr [2];
    int            sk_bit [2];
    bit            sk_val [2];

    always_ff @(posedge clk) begin
        if (mem_we) begin
            logic [DW-1:0] v;
            v = mem_wdata;
            for (int i = 0; i < 2; i++)
                if (sk_en[i] && sk_addr[i] == int'(mem_addr)) v[sk_bit[i]] = sk_val[i];
            ram[mem_addr] <= v;
        end
        if (mem_re) mem_rdata <= ram[mem_addr];
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One complete run, checked cycle by cycle.
    task automatic run(input bit algo, input bit lp, input bit poke,
                       input bit exp_fail, input int exp_faddr, input string tag);
        @(negedge clk);
        algo_sel = algo;
        lp_mode  = lp;
        start    = 1'b1;
        for (int k = 1; k <= 4 * DEPTH + 3; k++) begin
            @(negedge clk);
            start = (poke && k == 9);
            if (k <= 4 * DEPTH) begin
                int a, s, c;
                logic [DW-1:0]   pat, wd;
                logic [NCOL-1:0] pe;
                longint act, exp;
                a   = (k - 1) / 4;
                s   = (k - 1) % 4;
                c   = a % NCOL;
                pat = (algo && (a % 2 == 1)) ? '1 : '0;
                wd  = (s >= 2) ? ~pat : pat;
                if (lp) pe = NCOL'((1 << c) | ((c < NCOL - 1) ? (1 << (c + 1)) : 0));
                else    pe = '1;
                exp = {32'(a), 1'b0, (s % 2 == 0), (s % 2 == 1),
                       ((s % 2 == 0) ? wd : 8'h00), pe};
                act = {32'(mem_addr), done, mem_we, mem_re,
                       (mem_we ? mem_wdata : 8'h00), col_prech};
                chk(act == exp, {tag, " R2/R3/R4/R8/R9 op"}, act, exp);
            end else if (k == 4 * DEPTH + 1) begin
                chk(!mem_we && !mem_re && col_prech == '0 && !done,
                    {tag, " R6/R9 drain"}, {mem_we, mem_re, col_prech, done}, 0);
            end else if (k == 4 * DEPTH + 2) begin
                chk(done, {tag, " R6 done"}, done, 1);
                chk(fail == exp_fail, {tag, " R5/R10 fail"}, fail, exp_fail);
                if (exp_fail)
                    chk(int'(fail_addr) == exp_faddr, {tag, " R5 fail_addr"},
                        fail_addr, exp_faddr);
            end else begin
                chk(!done, {tag, " R6 one-cycle done"}, done, 0);
            end
        end
    endtask

    initial begin
        for (int i = 0; i < 2; i++) begin
            sk_en[i] = 1'b0; sk_addr[i] = 0; sk_bit[i] = 0; sk_val[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        chk(!done && !fail && !mem_we && !mem_re && col_prech == '0 && fail_addr == '0,
            "R1 reset", {done, fail, mem_we, mem_re, col_prech, fail_addr}, 0);

        // Clean zero-one, restricted precharge, start poked mid-run (R7).
        run(1'b0, 1'b1, 1'b1, 1'b0, 0, "zo-lp R7");
        // Clean checkerboard, full precharge.
        run(1'b1, 1'b0, 1'b0, 1'b0, 0, "cb-full");
        // Zero-one, stuck-at-0 at address 5 bit 7.
        sk_en[0] = 1'b1; sk_addr[0] = 5; sk_bit[0] = 7; sk_val[0] = 1'b0;
        run(1'b0, 1'b1, 1'b0, 1'b1, 5, "zo-sa0");
        // Checkerboard, stuck-at-1 at 6 and stuck-at-0 at 11: first address kept.
        sk_addr[0] = 6;  sk_bit[0] = 2; sk_val[0] = 1'b1;
        sk_en[1] = 1'b1; sk_addr[1] = 11; sk_bit[1] = 0; sk_val[1] = 1'b0;
        run(1'b1, 1'b1, 1'b0, 1'b1, 6, "cb-two");
        // Clean again: fail cleared by the new start (R10).
        sk_en[0] = 1'b0; sk_en[1] = 1'b0;
        run(1'b0, 1'b0, 1'b0, 1'b0, 0, "zo-clean R10");
        // Checkerboard, stuck-at-0 at address 0: fails on the inverse read.
        sk_en[0] = 1'b1; sk_addr[0] = 0; sk_bit[0] = 4; sk_val[0] = 1'b0;
        run(1'b1, 1'b1, 1'b0, 1'b1, 0, "cb-a0");

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(8 * 20000);
        if (!finished) begin
            n_run++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end

endmodule